// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the host write path of a byte-wide parallel NOR flash and turns bus write cycles into operation requests. Each bus write presents an address, a data byte and a write strobe; the block samples the strobe in the system clock domain, treats every rising edge as exactly one bus cycle, and steps through unlock-protected command sequences. When a sequence completes it raises a single-cycle request: program one byte, erase a sector, erase a block, erase the whole chip, enter identification mode, enter query mode, or return to read mode.

A command is accepted only after a fixed two-write unlock pattern. Erase commands require a second unlock before the final write. Any write that breaks the expected pattern drops the sequence and returns the block to read mode. While the array reports a program or erase in progress, every write is ignored. For erases, the block extracts the sector or block number from the final write's address. The current mode (read, identification, query) is always visible on an output.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode output is read (0), no request is raised, and no sequence is in progress.
- R2: Command cycles compare only address bits 14..0; bits above 14 may hold any value without changing the outcome.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any fourth write raise prog_req for one cycle, with prog_addr and prog_data equal to the fourth write's full address and data; the mode becomes read.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h at any address raise sect_erase_req, with erase_sector equal to that address shifted right by 12 (4 KB sectors).
- R5: The same five leading writes followed by 50h at any address raise blk_erase_req, with erase_block equal to that address shifted right by 16 (64 KB blocks).
- R6: The same five leading writes followed by 10h@5555h raise chip_erase_req; 10h at any other address aborts with no request.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h raises id_req and sets mode to 1 (identification); the same with 98h raises query_req and sets mode to 2 (query).
- R8: A single F0h write at any address when no sequence is in progress, or AAh@5555h, 55h@2AAAh, F0h@5555h, raises exit_req and sets mode to 0.
- R9: A write that does not match the next expected cycle raises no request, sets mode to 0, and leaves no partial sequence behind.
- R10: A strobe edge while busy is high is ignored: no request, no mode change, and the partial sequence in progress is kept.
- R11: A strobe held high over several clocks counts as one bus cycle, and each request lasts exactly one clock.
- R12: At most one request is raised in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | Bus write strobe, rising edge marks one write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| busy | input | 1 | High while an internal program or erase runs |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | ADDR_W | Byte address to program |
| prog_data | output | 8 | Byte value to program |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| erase_sector | output | ADDR_W-12 | Sector number to erase |
| blk_erase_req | output | 1 | One-cycle block erase request |
| erase_block | output | ADDR_W-16 | Block number to erase |
| chip_erase_req | output | 1 | One-cycle whole-chip erase request |
| id_req | output | 1 | One-cycle identification mode entry |
| query_req | output | 1 | One-cycle query mode entry |
| exit_req | output | 1 | One-cycle return to read mode |
| mode | output | 2 | Current mode: 0 read, 1 identification, 2 query |

## Verification
The bench builds the decoder with an 18-bit address, which leaves three don't-care bits above the compared range, 64 sectors and 4 blocks. That small space lets it erase every sector and every block, program every data byte value, and break the erase sequence at each of its six positions in turn, with sector and block numbers computed by shifting the address. The busy, held-strobe and mode-fallback cases are run on top of that same configuration.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_strobe,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      busy,
  output logic                      prog_req,
  output logic [ADDR_W-1:0]         prog_addr,
  output logic [7:0]                prog_data,
  output logic                      sect_erase_req,
  output logic [ADDR_W-SECT_LSB-1:0] erase_sector,
  output logic                      blk_erase_req,
  output logic [ADDR_W-BLK_LSB-1:0]  erase_block,
  output logic                      chip_erase_req,
  output logic                      id_req,
  output logic                      query_req,
  output logic                      exit_req,
  output logic [1:0]                mode
);
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] KEY_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_B = 15'h2AAA;
  localparam logic [1:0] M_READ = 2'd0, M_ID = 2'd1, M_QRY = 2'd2;
  localparam int Q_PROG = 0, Q_SECT = 1, Q_BLK = 2, Q_CHIP = 3,
                 Q_ID = 4, Q_QRY = 5, Q_EXIT = 6, NREQ = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PRG, S_E3, S_E4, S_E5
  } seq_t;

  seq_t            st, nst;
  logic [1:0]      nmode;
  logic [NREQ-1:0] req, nreq;
  logic            strobe_q;

  wire edge_seen = wr_strobe & ~strobe_q;
  wire live      = edge_seen & ~busy;
  wire at_a      = wr_addr[CMP_W-1:0] == KEY_A;
  wire at_b      = wr_addr[CMP_W-1:0] == KEY_B;

  always_comb begin
    nst   = S_IDLE;
    nmode = M_READ;
    nreq  = '0;
    unique case (st)
      S_IDLE:
        if (at_a && wr_data == 8'hAA) begin nst = S_U1; nmode = mode; end
        else if (wr_data == 8'hF0) nreq[Q_EXIT] = 1'b1;
      S_U1:
        if (at_b && wr_data == 8'h55) begin nst = S_U2; nmode = mode; end
      S_U2:
        if (at_a) begin
          case (wr_data)
            8'hA0: begin nst = S_PRG; nmode = mode; end
            8'h80: begin nst = S_E3;  nmode = mode; end
            8'h90: begin nmode = M_ID;  nreq[Q_ID]  = 1'b1; end
            8'h98: begin nmode = M_QRY; nreq[Q_QRY] = 1'b1; end
            8'hF0: nreq[Q_EXIT] = 1'b1;
            default: ;
          endcase
        end
      S_PRG: nreq[Q_PROG] = 1'b1;
      S_E3:
        if (at_a && wr_data == 8'hAA) begin nst = S_E4; nmode = mode; end
      S_E4:
        if (at_b && wr_data == 8'h55) begin nst = S_E5; nmode = mode; end
      S_E5:
        case (wr_data)
          8'h30: nreq[Q_SECT] = 1'b1;
          8'h50: nreq[Q_BLK]  = 1'b1;
          8'h10: nreq[Q_CHIP] = at_a;
          default: ;
        endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q     <= 1'b1;
      st           <= S_IDLE;
      mode         <= M_READ;
      req          <= '0;
      prog_addr    <= '0;
      prog_data    <= '0;
      erase_sector <= '0;
      erase_block  <= '0;
    end else begin
      strobe_q <= wr_strobe;
      req      <= '0;
      if (live) begin
        st   <= nst;
        mode <= nmode;
        req  <= nreq;
        if (nreq[Q_PROG]) begin
          prog_addr <= wr_addr;
          prog_data <= wr_data;
        end
        if (nreq[Q_SECT]) erase_sector <= wr_addr[ADDR_W-1:SECT_LSB];
        if (nreq[Q_BLK])  erase_block  <= wr_addr[ADDR_W-1:BLK_LSB];
      end
    end
  end

  assign prog_req       = req[Q_PROG];
  assign sect_erase_req = req[Q_SECT];
  assign blk_erase_req  = req[Q_BLK];
  assign chip_erase_req = req[Q_CHIP];
  assign id_req         = req[Q_ID];
  assign query_req      = req[Q_QRY];
  assign exit_req       = req[Q_EXIT];
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_strobe,
  input logic       busy,
  input logic       prog_req,
  input logic       sect_erase_req,
  input logic       blk_erase_req,
  input logic       chip_erase_req,
  input logic       id_req,
  input logic       query_req,
  input logic       exit_req,
  input logic [1:0] mode
);
  wire [6:0] reqs = {exit_req, query_req, id_req, chip_erase_req,
                     blk_erase_req, sect_erase_req, prog_req};

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  // R10
  busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe) && busy |=> reqs == 7'd0 && $stable(mode));

  // R11
  req_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqs != 7'd0 |-> $past(wr_strobe) && !$past(wr_strobe, 2));

  // R11
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(wr_strobe) |=> $stable(mode));

  // R7
  id_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_req |-> mode == 2'd1);

  // R7
  query_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_req |-> mode == 2'd2);

  // R8
  exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> mode == 2'd0);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .busy(busy),
  .prog_req(prog_req), .sect_erase_req(sect_erase_req),
  .blk_erase_req(blk_erase_req), .chip_erase_req(chip_erase_req),
  .id_req(id_req), .query_req(query_req), .exit_req(exit_req), .mode(mode)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 18;
  localparam logic [6:0] NONE = 7'd0, P_PROG = 7'd1, P_SECT = 7'd2, P_BLK = 7'd4,
                         P_CHIP = 7'd8, P_ID = 7'd16, P_QRY = 7'd32, P_EXIT = 7'd64;

  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic prog_req, sect_erase_req, blk_erase_req, chip_erase_req, id_req, query_req, exit_req;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;
  logic [AW-13:0] erase_sector;
  logic [AW-17:0] erase_block;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [6:0] snap, after;
  logic [1:0] snap_mode;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(stb), .wr_addr(addr), .wr_data(data),
    .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .sect_erase_req(sect_erase_req), .erase_sector(erase_sector),
    .blk_erase_req(blk_erase_req), .erase_block(erase_block),
    .chip_erase_req(chip_erase_req), .id_req(id_req), .query_req(query_req),
    .exit_req(exit_req), .mode(mode));

  wire [6:0] reqs = {exit_req, query_req, id_req, chip_erase_req,
                     blk_erase_req, sect_erase_req, prog_req};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk); addr = a; data = d; stb = 1'b1;
    @(negedge clk); snap = reqs; snap_mode = mode;
    repeat (hold - 1) @(negedge clk);
    stb = 1'b0;
    @(negedge clk); after = reqs;
  endtask

  function automatic logic [AW-1:0] ka(input logic [2:0] hi);
    return {hi, 15'h5555};
  endfunction
  function automatic logic [AW-1:0] kb(input logic [2:0] hi);
    return {hi, 15'h2AAA};
  endfunction

  task automatic erase_pre(input logic [2:0] hi);
    wr(ka(hi), 8'hAA); wr(kb(hi), 8'h55); wr(ka(hi), 8'h80);
    wr(ka(hi), 8'hAA); wr(kb(hi), 8'h55);
  endtask

  task automatic unlock(input logic [2:0] hi);
    wr(ka(hi), 8'hAA); wr(kb(hi), 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(mode == 2'd0, "R1 mode after reset", mode, 0);
    check(reqs == NONE, "R1 requests after reset", reqs, 0);

    // R4 R2: every sector, high address bits varied on unlock cycles
    for (int s = 0; s < 64; s++) begin
      logic [AW-1:0] a;
      a = AW'((s << 12) | ((s * 37) & 12'hFFF));
      erase_pre(3'(s));
      wr(a, 8'h30);
      check(snap == P_SECT, "R4 sector request", snap, P_SECT);
      check(erase_sector == 6'(a >> 12), "R4 sector number", erase_sector, a >> 12);
    end

    // R5
    for (int b = 0; b < 4; b++) begin
      for (int o = 0; o < 3; o++) begin
        logic [AW-1:0] a;
        a = AW'((b << 16) | (o * 16'h5A5B));
        erase_pre(3'(b + o));
        wr(a, 8'h50);
        check(snap == P_BLK, "R5 block request", snap, P_BLK);
        check(erase_block == 2'(a >> 16), "R5 block number", erase_block, a >> 16);
      end
    end

    // R3 R2: every data value
    for (int d = 0; d < 256; d++) begin
      logic [AW-1:0] a;
      a = AW'((d * 1031) % (1 << AW));
      unlock(3'(7 - (d % 8)));
      wr(ka(3'(d)), 8'hA0);
      wr(a, 8'(d));
      check(snap == P_PROG, "R3 program request", snap, P_PROG);
      check(prog_addr == a && prog_data == 8'(d), "R3 program payload", prog_data, d);
    end

    // R6
    erase_pre(3'd5); wr(ka(3'd2), 8'h10);
    check(snap == P_CHIP, "R6 chip erase", snap, P_CHIP);
    erase_pre(3'd0); wr(18'h01234, 8'h10);
    check(snap == NONE, "R6 chip erase wrong address", snap, 0);

    // R7
    unlock(3'd1); wr(ka(3'd0), 8'h90);
    check(snap == P_ID && snap_mode == 2'd1, "R7 id entry", {snap_mode, snap}, {2'd1, P_ID});
    unlock(3'd0); wr(ka(3'd4), 8'h98);
    check(snap == P_QRY && snap_mode == 2'd2, "R7 query entry", {snap_mode, snap}, {2'd2, P_QRY});

    // R8: single-write exit at an arbitrary address, and three-cycle form
    wr(18'h3ABCD, 8'hF0);
    check(snap == P_EXIT && snap_mode == 2'd0, "R8 short exit", {snap_mode, snap}, {2'd0, P_EXIT});
    unlock(3'd0); wr(ka(3'd0), 8'h90);
    unlock(3'd3); wr(ka(3'd6), 8'hF0);
    check(snap == P_EXIT && snap_mode == 2'd0, "R8 long exit", {snap_mode, snap}, {2'd0, P_EXIT});

    // R9: break the erase sequence at each position while in id mode
    for (int k = 0; k < 6; k++) begin
      logic [7:0] seqd [6];
      logic [AW-1:0] seqa [6];
      seqd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
      seqa = '{ka(0), kb(0), ka(0), ka(0), kb(0), ka(0)};
      unlock(3'd0); wr(ka(3'd0), 8'h90);
      for (int j = 0; j < 6; j++) begin
        if (j == k) begin
          wr(seqa[j], seqd[j] ^ 8'h01);
          check(snap == NONE && snap_mode == 2'd0, "R9 abort", {snap_mode, snap}, 0);
          break;
        end
        wr(seqa[j], seqd[j]);
      end
      erase_pre(3'd0); wr(ka(3'd0), 8'h10);
      check(snap == P_CHIP, "R9 fresh sequence after abort", snap, P_CHIP);
    end

    // R10: busy writes ignored, partial sequence kept, mode kept
    unlock(3'd0); wr(ka(3'd0), 8'h90);
    busy = 1'b1; wr(18'h00000, 8'hF0); busy = 1'b0;
    check(snap == NONE && snap_mode == 2'd1, "R10 exit ignored while busy", {snap_mode, snap}, {2'd1, NONE});
    unlock(3'd0);
    busy = 1'b1; wr(ka(3'd0), 8'h33); busy = 1'b0;
    check(snap == NONE && snap_mode == 2'd1, "R10 stray write while busy", {snap_mode, snap}, {2'd1, NONE});
    wr(ka(3'd0), 8'hA0); wr(18'h12345, 8'h6C);
    check(snap == P_PROG && prog_data == 8'h6C, "R10 sequence kept across busy", snap, P_PROG);

    // R11: held strobe counts once, request lasts one clock
    wr(ka(3'd0), 8'hAA, 4); wr(kb(3'd0), 8'h55, 3); wr(ka(3'd0), 8'hA0, 5);
    wr(18'h2F00F, 8'h81, 4);
    check(snap == P_PROG && prog_addr == 18'h2F00F, "R11 held strobe one cycle", snap, P_PROG);
    check(after == NONE, "R11 request one clock", after, 0);

    // R12
    check($countones(snap) <= 1, "R12 single request", snap, P_PROG);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule